// File: doc/BRIEF.md
# Serial Peripheral Byte Shifter (Master/Slave)

This block moves one byte at a time over a four-wire synchronous serial link (SCK, MOSI, MISO and an active-low select). It can run as the clock-generating master or as a slave clocked from outside. A host reaches it through three registers: control, status and data. A host write to the data register in master mode starts an exchange. In slave mode the same write preloads the byte that is returned on MISO at the next select.

Transmission has a single buffer. Reception has two, so the last completed byte stays readable while the next one shifts in. A data write that arrives while a byte is moving is dropped and raises a collision flag. Once a flag is up, further data writes are locked out until the host runs the clearing sequence: a status read that sees the flag, then an access to the data register.

Register map. Address 0 is control: bit 0 enable, bit 1 master select, bit 2 clock polarity, bit 3 clock phase, bits 5:4 rate code. Address 1 is status: bit 7 byte-done flag, bit 6 collision flag. Address 2 is data. Address 3 reads zero.

Top module: `spi_xfer_unit`

## Requirements
- R1: After reset the control, status and receive registers read 0, SCK is low and MISO is not driven.
- R2: In master mode with enable set, a data write produces exactly 16 SCK edges, and MOSI carries the written byte most significant bit first.
- R3: The master SCK half-period is 1, 2, 8 or 16 system clocks for rate codes 0, 1, 2 or 3.
- R4: SCK idles at the polarity bit. With phase 0, data is sampled on the edge leaving idle. With phase 1, it is sampled on the edge returning to idle.
- R5: The done flag rises one system clock after the eighth sampling edge, and the received byte is readable from that same clock. In master mode this is 15h+1 clocks after the data write (phase 0) or 16h+1 clocks after it (phase 1), where h is the half-period.
- R6: A data write during an active byte is discarded and sets the collision flag one clock later. The byte in progress completes unchanged.
- R7: While done or collision is set, data writes are ignored. A status read that sees a flag, followed by a read or write of the data register, clears both flags and unlocks writes.
- R8: The data register keeps returning the previous received byte while a new byte is shifting.
- R9: In slave mode, select high leaves MISO undriven and SCK activity is ignored. With select low, the slave takes MOSI into its receive buffer and returns the preloaded byte MSB first. With phase 0, the MSB is on MISO as soon as select falls.
- R10: With enable clear, data writes start nothing and the done flag stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe (has side effects on status/data) |
| host_addr | input | 2 | Register address |
| host_wdata | input | W | Host write data |
| host_rdata | output | W | Register read data, combinational from address |
| sck_in | input | 1 | Serial clock from an external master (slave mode) |
| sck_out | output | 1 | Serial clock generated in master mode |
| mosi_in | input | 1 | Serial data in for slave mode |
| mosi_out | output | 1 | Serial data out for master mode |
| miso_in | input | 1 | Serial data in for master mode |
| miso_out | output | 1 | Serial data out for slave mode |
| miso_oe | output | 1 | Drive enable for miso_out |
| ss_n | input | 1 | Active-low slave select |

## Verification
In master mode, the done flag and the receive buffer are due exactly 15h+1 clocks after the clock that takes the data write (16h+1 with phase 1). The bench counts falling edges from that clock and requires the flag on that count and not before. A collision flag is due one clock after the offending write, and an SCK edge appears one clock after the matching divider tick. The bench samples every output on the falling edge after the edge that updates it. In slave mode the inputs pass through a two-stage synchronizer. The bench therefore holds each serial clock phase for 8 system clocks and samples MISO just before the edge on which the external master would capture it.

// File: rtl/spi_pkg.sv
// Package: shared control-register type and host address map for the
// serial byte shifter. Assumes an 8-bit or wider host data path.
package spi_pkg;
    typedef struct packed {
        logic [1:0] rate;
        logic       cpha;
        logic       cpol;
        logic       master;
        logic       en;
    } spi_ctrl_t;

    localparam logic [1:0] ADR_CTRL = 2'd0;
    localparam logic [1:0] ADR_STAT = 2'd1;
    localparam logic [1:0] ADR_DATA = 2'd2;
endpackage

// File: rtl/spi_rate_gen.sv
// Module: master clock divider. Emits a one-cycle tick every half SCK
// period while run is high; half-period is 1, 2, 8 or 16 system clocks.
// Assumes DIVW is wide enough to hold the largest half-period minus one.
module spi_rate_gen #(
    parameter int DIVW = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] rate,
    output logic       tick
);
    logic [DIVW-1:0] cnt;
    logic [DIVW-1:0] half_m1;

    // Terminal count for the selected rate.
    always_comb begin
        half_m1 = (rate[1] ? (DIVW'(8) << rate[0]) : (DIVW'(1) << rate[0])) - DIVW'(1);
        tick    = run && (cnt == half_m1);
    end

    // Half-period counter, cleared while idle and at each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (!run || tick) cnt <= '0;
        else                   cnt <= cnt + DIVW'(1);
    end
endmodule

// File: rtl/spi_shift_core.sv
// Module: shared shift engine for master and slave modes. Counts SCK edges,
// samples on phase-selected edges, shifts MSB first and pulses complete one
// clock after the eighth sample. Slave inputs are synchronized with two
// flops, so the external SCK must be slow against clk.
module spi_shift_core #(
    parameter int W  = 8,
    parameter int CW = $clog2(2 * W)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         master,
    input  logic         cpol,
    input  logic         cpha,
    input  logic         tick,
    input  logic         start,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         sck_in,
    input  logic         mosi_in,
    input  logic         miso_in,
    input  logic         ss_n,
    output logic         sck_o,
    output logic         ser_o,
    output logic [W-1:0] shreg_o,
    output logic         active,
    output logic         complete,
    output logic         sel_o,
    output logic         mrun
);
    logic [1:0]    sck_sy, ss_sy, mosi_sy;
    logic          sck_prev, ss_prev;
    logic [CW-1:0] cnt;
    logic          fin, mbusy, sck_q, ser_q;
    logic [W-1:0]  shreg;
    logic          sel, ev, samp, last, in_bit;

    // Two-stage synchronizers for the slave-side inputs plus edge history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_sy   <= '0;
            ss_sy    <= '1;
            mosi_sy  <= '0;
            sck_prev <= 1'b0;
            ss_prev  <= 1'b1;
        end else begin
            sck_sy   <= {sck_sy[0], sck_in};
            ss_sy    <= {ss_sy[0], ss_n};
            mosi_sy  <= {mosi_sy[0], mosi_in};
            sck_prev <= sck_sy[1];
            ss_prev  <= ss_sy[1];
        end
    end

    // Edge event, sampling-edge and last-sample decode.
    always_comb begin
        sel    = !master && !ss_sy[1];
        ev     = master ? (mbusy && tick && !fin) : (sel && (sck_sy[1] != sck_prev));
        in_bit = master ? miso_in : mosi_sy[1];
        samp   = (cnt[0] == cpha);
        last   = samp && (cnt == (CW'(2 * W - 2) | CW'(cpha)));
    end

    // Shift register, edge counter, master clock and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            ser_q <= 1'b0;
            cnt   <= '0;
            fin   <= 1'b0;
            mbusy <= 1'b0;
            sck_q <= 1'b0;
        end else if (!en) begin
            cnt   <= '0;
            fin   <= 1'b0;
            mbusy <= 1'b0;
            sck_q <= cpol;
        end else begin
            fin <= ev && last;
            if (fin && master) mbusy <= 1'b0;
            if (!mbusy || fin) sck_q <= cpol;
            else if (ev)       sck_q <= ~sck_q;
            if (start || load) begin
                shreg <= din;
                ser_q <= din[W-1];
                if (start) begin
                    mbusy <= 1'b1;
                    cnt   <= '0;
                end
            end else if (ev) begin
                cnt <= cnt + CW'(1);
                if (samp) shreg <= {shreg[W-2:0], in_bit};
                else      ser_q <= shreg[W-1];
            end else if (!master && ss_prev && !ss_sy[1]) begin
                cnt   <= '0;
                ser_q <= shreg[W-1];
            end
            if (!master && ss_sy[1]) cnt <= '0;
        end
    end

    // Output view of the engine state.
    always_comb begin
        sck_o    = sck_q;
        ser_o    = ser_q;
        shreg_o  = shreg;
        active   = master ? mbusy : (cnt != '0);
        complete = fin;
        sel_o    = sel;
        mrun     = mbusy;
    end
endmodule

// File: rtl/spi_xfer_unit.sv
// Module: top of the serial byte shifter. Holds the host registers (control,
// status flags, receive buffer) and decodes the write/collision/lock rules
// around the shared shift engine and the master rate divider.
// Assumes W >= 8 so the control and status fields fit the host data path.
module spi_xfer_unit #(
    parameter int W    = 8,
    parameter int DIVW = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         host_wr,
    input  logic         host_rd,
    input  logic [1:0]   host_addr,
    input  logic [W-1:0] host_wdata,
    output logic [W-1:0] host_rdata,
    input  logic         sck_in,
    output logic         sck_out,
    input  logic         mosi_in,
    output logic         mosi_out,
    input  logic         miso_in,
    output logic         miso_out,
    output logic         miso_oe,
    input  logic         ss_n
);
    import spi_pkg::*;

    localparam int CTRLW = $bits(spi_ctrl_t);

    spi_ctrl_t    ctrl_q;
    logic         done_q, wcol_q, armed_q;
    logic [W-1:0] rx_buf;
    logic         en_w, master_w, cpol_w, cpha_w;
    logic         active_w, complete_w, sel_w, mrun_w, tick_w, ser_w;
    logic [W-1:0] shreg_w;
    logic         data_wr_w, data_acc_w, stat_rd_w, clear_seq, locked;
    logic         collide_w, accept_w, start_w, load_w;

    // Control field fan-out and host access decode.
    always_comb begin
        en_w       = ctrl_q.en;
        master_w   = ctrl_q.master;
        cpol_w     = ctrl_q.cpol;
        cpha_w     = ctrl_q.cpha;
        data_wr_w  = host_wr && (host_addr == ADR_DATA);
        data_acc_w = (host_wr || host_rd) && (host_addr == ADR_DATA);
        stat_rd_w  = host_rd && (host_addr == ADR_STAT);
        clear_seq  = armed_q && data_acc_w;
        locked     = (done_q || wcol_q) && !clear_seq;
        collide_w  = data_wr_w && en_w && active_w;
        accept_w   = data_wr_w && en_w && !active_w && !locked;
        start_w    = accept_w && master_w;
        load_w     = accept_w && !master_w;
    end

    // Control register write.
    always_ff @(posedge clk) begin
        if (!rst_n)                                    ctrl_q <= '0;
        else if (host_wr && host_addr == ADR_CTRL)     ctrl_q <= spi_ctrl_t'(host_wdata[CTRLW-1:0]);
    end

    // Status flags, clearing-sequence arm and receive buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q  <= 1'b0;
            wcol_q  <= 1'b0;
            armed_q <= 1'b0;
            rx_buf  <= '0;
        end else begin
            if (clear_seq)                            armed_q <= 1'b0;
            else if (stat_rd_w && (done_q || wcol_q)) armed_q <= 1'b1;
            if (complete_w)     done_q <= 1'b1;
            else if (clear_seq) done_q <= 1'b0;
            if (collide_w)      wcol_q <= 1'b1;
            else if (clear_seq) wcol_q <= 1'b0;
            if (complete_w)     rx_buf <= shreg_w;
        end
    end

    // Host read mux.
    always_comb begin
        case (host_addr)
            ADR_CTRL: host_rdata = {{(W-CTRLW){1'b0}}, ctrl_q};
            ADR_STAT: host_rdata = {done_q, wcol_q, {(W-2){1'b0}}};
            ADR_DATA: host_rdata = rx_buf;
            default:  host_rdata = '0;
        endcase
    end

    spi_rate_gen #(.DIVW(DIVW)) u_rate (
        .clk(clk), .rst_n(rst_n), .run(mrun_w), .rate(ctrl_q.rate), .tick(tick_w)
    );

    spi_shift_core #(.W(W)) u_core (
        .clk(clk), .rst_n(rst_n), .en(en_w), .master(master_w), .cpol(cpol_w),
        .cpha(cpha_w), .tick(tick_w), .start(start_w), .load(load_w),
        .din(host_wdata), .sck_in(sck_in), .mosi_in(mosi_in), .miso_in(miso_in),
        .ss_n(ss_n), .sck_o(sck_out), .ser_o(ser_w), .shreg_o(shreg_w),
        .active(active_w), .complete(complete_w), .sel_o(sel_w), .mrun(mrun_w)
    );

    // Serial pin outputs.
    always_comb begin
        mosi_out = en_w && master_w && ser_w;
        miso_out = ser_w;
        miso_oe  = en_w && !master_w && !ss_n;
    end
endmodule

// File: rtl/spi_xfer_chk.sv
// Module: property checker for the serial byte shifter, bound to the top.
// Observes the engine handshake and the host flags across cycles.
module spi_xfer_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic master,
    input logic cpol,
    input logic active,
    input logic complete,
    input logic start,
    input logic data_wr,
    input logic sel,
    input logic done,
    input logic wcol,
    input logic sck
);
    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> active);

    // R4
    sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && master && !active && $past(en && master && !active) && $stable(cpol))
        |-> (sck == cpol));

    // R5
    done_after_complete_chk: assert property (@(posedge clk) disable iff (!rst_n)
        complete |=> done);

    // R6
    collide_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && en && active) |=> wcol);

    // R9
    slave_unselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !master && !sel) |=> !complete);

    // R10
    disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!active && !complete));
endmodule

bind spi_xfer_unit spi_xfer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .en(en_w), .master(master_w), .cpol(cpol_w),
    .active(active_w), .complete(complete_w), .start(start_w),
    .data_wr(data_wr_w), .sel(sel_w), .done(done_q), .wcol(wcol_q), .sck(sck_out)
);

// File: tb/sim_spi_xfer_unit.sv
`timescale 1ns/1ps
module sim_spi_xfer_unit;
    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_DATA = 2'd2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [1:0] host_addr = A_STAT;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       sck_in = 1'b0, mosi_in = 1'b0, ss_n = 1'b1;
    logic       sck_out, mosi_out, miso_in, miso_out, miso_oe;
    int         checks = 0, fails = 0;

    always #2.5 clk = ~clk;
    assign miso_in = mosi_out;

    spi_xfer_unit u0 (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .sck_in(sck_in), .sck_out(sck_out), .mosi_in(mosi_in), .mosi_out(mosi_out),
        .miso_in(miso_in), .miso_out(miso_out), .miso_oe(miso_oe), .ss_n(ss_n)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hw(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; host_addr = A_STAT;
    endtask

    task automatic hr(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #1 v = host_rdata;
        @(negedge clk);
        host_rd = 1'b0; host_addr = A_STAT;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] v);
        host_addr = a;
        #1 v = host_rdata;
        host_addr = A_STAT;
    endtask

    task automatic wait_done(output int n);
        logic [7:0] v;
        n = 1;
        peek(A_STAT, v);
        while (!v[7] && n < 1000) begin
            @(negedge clk); n++;
            peek(A_STAT, v);
        end
    endtask

    task automatic run_master(input logic [1:0] rate, input logic cpol, input logic cpha, input logic [7:0] tx);
        logic [7:0] v, cap;
        int n, edges, h, exp_n;
        logic prev, fin_seen;
        hw(A_CTRL, {2'b00, rate, cpha, cpol, 1'b1, 1'b1});
        repeat (2) @(negedge clk);
        chk(sck_out == cpol, "R4 idle level", sck_out, cpol);
        h = rate[1] ? (8 << rate[0]) : (1 << rate[0]);
        exp_n = (cpha ? 16 : 15) * h + 2;
        hw(A_DATA, tx);
        n = 1; edges = 0; cap = '0; prev = cpol; fin_seen = 1'b0;
        while (!fin_seen && n < 1000) begin
            if (sck_out !== prev) begin
                prev = sck_out;
                if (edges < 16 && ((sck_out != cpol) == (cpha == 1'b0))) cap = {cap[6:0], mosi_out};
                edges++;
            end
            peek(A_STAT, v);
            fin_seen = v[7];
            if (!fin_seen) begin @(negedge clk); n++; end
        end
        chk(n == exp_n, "R3 R5 done latency", n, exp_n);
        chk(edges == 16, "R2 sck edge count", edges, 16);
        chk(cap == tx, "R2 mosi msb first", cap, tx);
        hr(A_STAT, v);
        chk(v[7] == 1'b1, "R5 done flag", v, 8'h80);
        hr(A_DATA, v);
        chk(v == tx, "R4 sampled byte", v, tx);
        peek(A_STAT, v);
        chk(v == 8'h00, "R7 sequence clears", v, 8'h00);
    endtask

    task automatic run_slave(input logic cpol, input logic cpha, input logic [7:0] m, input logic [7:0] txs);
        logic [7:0] v, cap;
        hw(A_CTRL, {4'b0000, cpha, cpol, 1'b0, 1'b1});
        sck_in = cpol; ss_n = 1'b1; mosi_in = 1'b0;
        repeat (4) @(negedge clk);
        chk(miso_oe == 1'b0, "R9 unselected undriven", miso_oe, 0);
        for (int k = 0; k < 16; k++) begin
            sck_in = ~sck_in; repeat (4) @(negedge clk);
        end
        peek(A_STAT, v);
        chk(v == 8'h00, "R9 sck ignored unselected", v, 8'h00);
        hw(A_DATA, txs);
        ss_n = 1'b0;
        repeat (4) @(negedge clk);
        chk(miso_oe == 1'b1, "R9 selected drives", miso_oe, 1);
        if (!cpha) chk(miso_out == txs[7], "R9 msb at select", miso_out, txs[7]);
        cap = '0;
        for (int k = 0; k < 8; k++) begin
            if (!cpha) begin
                mosi_in = m[7-k];
                repeat (8) @(negedge clk);
                cap = {cap[6:0], miso_out};
                sck_in = ~cpol;
                repeat (8) @(negedge clk);
                sck_in = cpol;
            end else begin
                sck_in = ~cpol; mosi_in = m[7-k];
                repeat (8) @(negedge clk);
                cap = {cap[6:0], miso_out};
                sck_in = cpol;
                repeat (8) @(negedge clk);
            end
        end
        repeat (8) @(negedge clk);
        hr(A_STAT, v);
        chk(v[7] == 1'b1, "R5 slave done", v, 8'h80);
        hr(A_DATA, v);
        chk(v == m, "R9 slave receive", v, m);
        chk(cap == txs, "R9 slave transmit", cap, txs);
        ss_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int n;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        peek(A_CTRL, v); chk(v == 8'h00, "R1 control reset", v, 0);
        peek(A_STAT, v); chk(v == 8'h00, "R1 status reset", v, 0);
        peek(A_DATA, v); chk(v == 8'h00, "R1 data reset", v, 0);
        chk(sck_out == 1'b0, "R1 sck low", sck_out, 0);
        chk(miso_oe == 1'b0, "R1 miso undriven", miso_oe, 0);

        // Master sweep over every rate, polarity and phase
        for (int c = 0; c < 16; c++) begin
            run_master(c[3:2], c[1], c[0], 8'h96 ^ 8'(c * 37));
        end

        // R6 collision, R7 lock, R8 double buffering
        hw(A_CTRL, 8'h33);
        hw(A_DATA, 8'hA5);
        repeat (30) @(negedge clk);
        hw(A_DATA, 8'h3C);
        peek(A_STAT, v); chk(v == 8'h40, "R6 collision flag", v, 8'h40);
        wait_done(n);
        peek(A_STAT, v); chk(v == 8'hC0, "R6 both flags", v, 8'hC0);
        hw(A_DATA, 8'h11);
        repeat (20) @(negedge clk);
        chk(sck_out == 1'b0, "R7 locked write starts nothing", sck_out, 0);
        peek(A_STAT, v); chk(v == 8'hC0, "R7 flags held", v, 8'hC0);
        hr(A_STAT, v);
        hr(A_DATA, v); chk(v == 8'hA5, "R6 byte undisturbed", v, 8'hA5);
        peek(A_STAT, v); chk(v == 8'h00, "R7 flags cleared", v, 0);
        hw(A_DATA, 8'h5A);
        repeat (100) @(negedge clk);
        peek(A_DATA, v); chk(v == 8'hA5, "R8 old byte held", v, 8'hA5);
        wait_done(n);
        hr(A_STAT, v);
        hr(A_DATA, v); chk(v == 8'h5A, "R8 new byte", v, 8'h5A);

        // R10 disabled block
        hw(A_CTRL, 8'h02);
        hw(A_DATA, 8'hFF);
        repeat (10) @(negedge clk);
        chk(sck_out == 1'b0, "R10 no clock", sck_out, 0);
        repeat (30) @(negedge clk);
        peek(A_STAT, v); chk(v == 8'h00, "R10 no done", v, 0);
        peek(A_DATA, v); chk(v == 8'h5A, "R10 buffer kept", v, 8'h5A);

        // Slave sweep over polarity and phase
        for (int c = 0; c < 4; c++) begin
            run_slave(c[1], c[0], 8'hC3 ^ 8'(c * 29), 8'h6B ^ 8'(c * 71));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule